// File: doc/BRIEF.md
# Half-Word to Word Register Access Adapter

This block sits between a bus master that issues 8-, 16- or 32-bit accesses and a register file that only understands whole 32-bit words. It makes a 32-bit register reachable through two 16-bit accesses while the register file still sees one atomic word access, so any side effect of a register read or write happens exactly once.

A 16-bit write to the lower half (address bit 1 clear) only parks its data in a write-side holding register. The following 16-bit write to the upper half (address bit 1 set) issues a single word write to the word-aligned address, with the new upper half on top of the parked lower half. A 16-bit read of the lower half performs one real word read, returns the lower 16 bits and keeps the upper 16 bits in a read-side holding register; a later upper-half read returns that kept value without touching the register file. Word accesses pass through unchanged, and byte accesses are refused with an error strobe.

The block is a small state machine. ST_IDLE accepts a request (up_ready high). Transitions: a local access (lower-half write, upper-half read, bad width) goes ST_IDLE to ST_RESP; a word write or upper-half write goes ST_IDLE to ST_ISSUE_WR to ST_RESP; a word read or lower-half read goes ST_IDLE to ST_ISSUE_RD to ST_RD_CAPT to ST_RESP. ST_RESP always returns to ST_IDLE. The register file answers a read one cycle after rf_req.

Top module: `hw2w_adapter`

## Requirements
- R1: After reset up_ready is 1, up_ack, up_err and rf_req are 0, and both holding registers read as zero (an upper-half read returns 0, an upper-half write places zero in the lower 16 bits).
- R2: A 16-bit write (up_size 2'b01, up_we 1) with up_addr[1] clear stores up_wdata[15:0] in the write holding register and makes no register file access.
- R3: A 16-bit write with up_addr[1] set makes exactly one register file write, to up_addr with its two low bits cleared, with data {up_wdata[15:0], write holding register}.
- R4: A 16-bit read with up_addr[1] clear makes exactly one register file read of the word-aligned address, returns {16'h0, word[15:0]} and keeps word[31:16] in the read holding register.
- R5: A 16-bit read with up_addr[1] set returns {16'h0, read holding register} and makes no register file access.
- R6: A 32-bit write (up_size 2'b10) makes one register file write with up_addr and up_wdata unchanged.
- R7: A 32-bit read makes one register file read of up_addr unchanged, returns the full word, and leaves the read holding register unchanged.
- R8: A request with up_size 2'b00 (byte) or 2'b11 is a bad width: its response carries up_err high for that one cycle with up_rdata zero, no register file access is made and neither holding register changes.
- R9: up_ready is low from the cycle after acceptance until the cycle after the response; a request presented while up_ready is low is ignored; rf_req never lasts more than one cycle.
- R10: Every accepted request gets exactly one one-cycle up_ack: 1 cycle after acceptance for local accesses, 2 cycles for register file writes, 3 cycles for register file reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Request, accepted when up_ready is high |
| up_we | input | 1 | 1 write, 0 read |
| up_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| up_addr | input | ADDR_W | Byte address |
| up_wdata | input | DATA_W | Write data (lower half used for half-word writes) |
| up_ready | output | 1 | Adapter idle, can accept a request |
| up_ack | output | 1 | One-cycle response strobe |
| up_err | output | 1 | Bad-width strobe, high with up_ack |
| up_rdata | output | DATA_W | Read data, valid with up_ack |
| rf_req | output | 1 | Register file access strobe |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | ADDR_W | Register file address |
| rf_wdata | output | DATA_W | Register file write data |
| rf_rdata | input | DATA_W | Register file read data, one cycle after rf_req |

## Verification
The bench goes after the ordering cases: an upper-half write straight after reset (a design that did not clear the write holding register would leak stale bits), an upper-half read after a word read (a design that let word reads refresh the read holding register would return the wrong half), and repeated upper-half reads (a design that touched the register file there would double a read side effect). It presents byte and reserved sizes between half accesses, where a faulty design would disturb a holding register or reach the register file, and it holds junk requests while the adapter is busy, where a design that sampled them would issue extra accesses or error strobes. Every cycle of every access is compared against the expected register file strobe, address, data and response timing.

// File: rtl/hw2w_pkg.sv
package hw2w_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_WR,
        ST_ISSUE_RD,
        ST_RD_CAPT,
        ST_RESP
    } adp_state_e;

    typedef enum logic [2:0] {
        OP_BAD,
        OP_WR_LO,
        OP_WR_HI,
        OP_RD_LO,
        OP_RD_HI,
        OP_WR_WORD,
        OP_RD_WORD
    } op_kind_e;

endpackage

// File: rtl/hw2w_decode.sv
module hw2w_decode
    import hw2w_pkg::*;
(
    input  logic     we,
    input  logic [1:0] size,
    input  logic     upper_sel,
    output op_kind_e op
);
    always_comb begin
        op = OP_BAD;
        unique case (acc_size_e'(size))
            SZ_HALF: begin
                if (we) op = upper_sel ? OP_WR_HI : OP_WR_LO;
                else    op = upper_sel ? OP_RD_HI : OP_RD_LO;
            end
            SZ_WORD: op = we ? OP_WR_WORD : OP_RD_WORD;
            SZ_BYTE: op = OP_BAD;
            SZ_RSVD: op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/hw2w_latches.sv
module hw2w_latches #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wlo_en,
    input  logic [HALF_W-1:0] wlo_data,
    input  logic              rhi_en,
    input  logic [HALF_W-1:0] rhi_data,
    output logic [HALF_W-1:0] wlat,
    output logic [HALF_W-1:0] rlat
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wlat <= '0;
        end else if (wlo_en) begin
            wlat <= wlo_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rlat <= '0;
        end else if (rhi_en) begin
            rlat <= rhi_data;
        end
    end
endmodule

// File: rtl/hw2w_fsm.sv
module hw2w_fsm
    import hw2w_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  op_kind_e          op,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [DATA_W/2-1:0] wlat,
    input  logic [DATA_W/2-1:0] rlat,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              up_ready,
    output logic              up_ack,
    output logic              up_err,
    output logic [DATA_W-1:0] up_rdata,
    output logic              rf_req,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              wlo_en,
    output logic [DATA_W/2-1:0] wlo_data,
    output logic              rhi_en,
    output logic [DATA_W/2-1:0] rhi_data
);
    localparam int HALF_W = DATA_W / 2;

    adp_state_e        state, state_nx;
    op_kind_e          cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic [DATA_W-1:0] rd_buf;
    logic              accept;

    assign accept = (state == ST_IDLE) && up_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // command capture and read buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_op    <= OP_BAD;
            cmd_addr  <= '0;
            cmd_wdata <= '0;
            rd_buf    <= '0;
        end else begin
            if (accept) begin
                cmd_op    <= op;
                cmd_addr  <= up_addr;
                cmd_wdata <= up_wdata;
            end
            if (state == ST_RD_CAPT) begin
                rd_buf <= rf_rdata;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (up_req) begin
                    unique case (op)
                        OP_WR_HI, OP_WR_WORD: state_nx = ST_ISSUE_WR;
                        OP_RD_LO, OP_RD_WORD: state_nx = ST_ISSUE_RD;
                        default:              state_nx = ST_RESP;
                    endcase
                end
            end
            ST_ISSUE_WR: state_nx = ST_RESP;
            ST_ISSUE_RD: state_nx = ST_RD_CAPT;
            ST_RD_CAPT:  state_nx = ST_RESP;
            ST_RESP:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        up_ready = 1'b0;
        up_ack   = 1'b0;
        up_err   = 1'b0;
        up_rdata = '0;
        rf_req   = 1'b0;
        rf_we    = 1'b0;
        rf_addr  = '0;
        rf_wdata = '0;
        wlo_en   = 1'b0;
        wlo_data = up_wdata[HALF_W-1:0];
        rhi_en   = 1'b0;
        rhi_data = rf_rdata[DATA_W-1:HALF_W];
        unique case (state)
            ST_IDLE: begin
                up_ready = 1'b1;
                wlo_en   = up_req && (op == OP_WR_LO);
            end
            ST_ISSUE_WR: begin
                rf_req = 1'b1;
                rf_we  = 1'b1;
                if (cmd_op == OP_WR_WORD) begin
                    rf_addr  = cmd_addr;
                    rf_wdata = cmd_wdata;
                end else begin
                    rf_addr  = {cmd_addr[ADDR_W-1:2], 2'b00};
                    rf_wdata = {cmd_wdata[HALF_W-1:0], wlat};
                end
            end
            ST_ISSUE_RD: begin
                rf_req = 1'b1;
                if (cmd_op == OP_RD_WORD) rf_addr = cmd_addr;
                else                      rf_addr = {cmd_addr[ADDR_W-1:2], 2'b00};
            end
            ST_RD_CAPT: begin
                rhi_en = (cmd_op == OP_RD_LO);
            end
            ST_RESP: begin
                up_ack = 1'b1;
                up_err = (cmd_op == OP_BAD);
                unique case (cmd_op)
                    OP_RD_WORD: up_rdata = rd_buf;
                    OP_RD_LO:   up_rdata = {{HALF_W{1'b0}}, rd_buf[HALF_W-1:0]};
                    OP_RD_HI:   up_rdata = {{HALF_W{1'b0}}, rlat};
                    default:    up_rdata = '0;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hw2w_adapter.sv
module hw2w_adapter
    import hw2w_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req,
    input  logic              up_we,
    input  logic [1:0]        up_size,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    output logic              up_ready,
    output logic              up_ack,
    output logic              up_err,
    output logic [DATA_W-1:0] up_rdata,
    output logic              rf_req,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);
    localparam int HALF_W = DATA_W / 2;

    op_kind_e          op;
    logic              wlo_en, rhi_en;
    logic [HALF_W-1:0] wlo_data, rhi_data, wlat, rlat;

    hw2w_decode u_decode (
        .we        (up_we),
        .size      (up_size),
        .upper_sel (up_addr[1]),
        .op        (op)
    );

    hw2w_latches #(.HALF_W(HALF_W)) u_latches (
        .clk      (clk),
        .rst_n    (rst_n),
        .wlo_en   (wlo_en),
        .wlo_data (wlo_data),
        .rhi_en   (rhi_en),
        .rhi_data (rhi_data),
        .wlat     (wlat),
        .rlat     (rlat)
    );

    hw2w_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_req   (up_req),
        .op       (op),
        .up_addr  (up_addr),
        .up_wdata (up_wdata),
        .wlat     (wlat),
        .rlat     (rlat),
        .rf_rdata (rf_rdata),
        .up_ready (up_ready),
        .up_ack   (up_ack),
        .up_err   (up_err),
        .up_rdata (up_rdata),
        .rf_req   (rf_req),
        .rf_we    (rf_we),
        .rf_addr  (rf_addr),
        .rf_wdata (rf_wdata),
        .wlo_en   (wlo_en),
        .wlo_data (wlo_data),
        .rhi_en   (rhi_en),
        .rhi_data (rhi_data)
    );
endmodule

// File: rtl/hw2w_adapter_chk.sv
module hw2w_adapter_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_ready,
    input logic              up_ack,
    input logic              up_err,
    input logic [DATA_W-1:0] up_rdata,
    input logic              rf_req
);
    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |=> !up_ack);

    // R9
    busy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |-> !up_ready);

    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_err |-> (up_ack && up_rdata == '0));

    // R9
    rf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |=> !rf_req);

    // R10
    rf_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_req |-> (!up_ready && !up_ack));
endmodule

bind hw2w_adapter hw2w_adapter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/hw2w_adapter_test.sv
module hw2w_adapter_test;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_req = 1'b0;
    logic          up_we = 1'b0;
    logic [1:0]    up_size = 2'b00;
    logic [AW-1:0] up_addr = '0;
    logic [DW-1:0] up_wdata = '0;
    logic          up_ready, up_ack, up_err, rf_req, rf_we;
    logic [DW-1:0] up_rdata, rf_wdata;
    logic [DW-1:0] rf_rdata = '0;
    logic [AW-1:0] rf_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mem [0:1023];
    logic [15:0] m_wlat = 16'h0;
    logic [15:0] m_rlat = 16'h0;

    always #10 clk = ~clk;

    hw2w_adapter #(.ADDR_W(AW), .DATA_W(DW)) uut (.*);

    // register file behind the adapter: one-cycle read latency
    always @(posedge clk) begin
        if (rf_req) begin
            if (rf_we) mem[rf_addr[AW-1:2]] <= rf_wdata;
            else       rf_rdata <= mem[rf_addr[AW-1:2]];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // one access; compared against the model on every clock until idle again
    task automatic access(input logic we, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] wd, input bit junk, input string tag);
        int          lat;
        int          rfk;     // 0 none, 1 write, 2 read
        logic [AW-1:0] eaddr;
        logic [31:0] ewd, erd;
        bit          eerr;
        logic [31:0] word;
        lat = 1; rfk = 0; eaddr = '0; ewd = '0; erd = '0; eerr = 0;
        word = mem[a[AW-1:2]];
        if (sz == 2'b01) begin
            if (we && !a[1]) begin
                m_wlat = wd[15:0];
            end else if (we) begin
                lat = 2; rfk = 1; eaddr = {a[AW-1:2], 2'b00}; ewd = {wd[15:0], m_wlat};
            end else if (!a[1]) begin
                lat = 3; rfk = 2; eaddr = {a[AW-1:2], 2'b00}; erd = {16'h0, word[15:0]};
                m_rlat = word[31:16];
            end else begin
                erd = {16'h0, m_rlat};
            end
        end else if (sz == 2'b10) begin
            eaddr = a;
            if (we) begin lat = 2; rfk = 1; ewd = wd; end
            else    begin lat = 3; rfk = 2; erd = word; end
        end else begin
            eerr = 1;
        end
        chk(up_ready === 1'b1, {tag, " ready before request"}, 32'(up_ready), 32'h1);
        up_req = 1; up_we = we; up_size = sz; up_addr = a; up_wdata = wd;
        for (int k = 1; k <= lat + 1; k++) begin
            @(negedge clk);
            if (junk && k < lat) begin
                // ignored while busy (R9): a byte read would raise an error if taken
                up_req = 1; up_we = 0; up_size = 2'b00; up_addr = '1; up_wdata = '1;
            end else begin
                up_req = 0;
            end
            chk(rf_req === (k == 1 && rfk != 0), {tag, " rf_req"}, 32'(rf_req), 32'(k == 1 && rfk != 0));
            if (k == 1 && rfk != 0) begin
                chk(rf_we === (rfk == 1), {tag, " rf_we"}, 32'(rf_we), 32'(rfk == 1));
                chk(rf_addr === eaddr, {tag, " rf_addr"}, 32'(rf_addr), 32'(eaddr));
                if (rfk == 1) chk(rf_wdata === ewd, {tag, " rf_wdata"}, rf_wdata, ewd);
            end
            chk(up_ack === (k == lat), {tag, " ack timing R10"}, 32'(up_ack), 32'(k == lat));
            chk(up_err === (k == lat && eerr), {tag, " err"}, 32'(up_err), 32'(k == lat && eerr));
            if (k == lat)
                chk(up_rdata === erd, {tag, " rdata"}, up_rdata, erd);
            chk(up_ready === (k == lat + 1), {tag, " ready R9"}, 32'(up_ready), 32'(k == lat + 1));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h01010101) ^ 32'hA5A50000;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(up_ready === 1'b1, "R1 ready", 32'(up_ready), 32'h1);
        chk(up_ack === 1'b0, "R1 ack", 32'(up_ack), 32'h0);
        chk(rf_req === 1'b0, "R1 rf_req", 32'(rf_req), 32'h0);
        rst_n = 1;
        @(negedge clk);
        access(0, 2'b01, 12'h012, 32'h0, 0, "R1 R5 upper read after reset");
        access(1, 2'b01, 12'h012, 32'h0000BEEF, 0, "R1 R3 upper write after reset");
        access(1, 2'b01, 12'h020, 32'hFFFF1234, 0, "R2 lower write");
        access(1, 2'b01, 12'h022, 32'h0000ABCD, 0, "R3 upper write");
        access(0, 2'b10, 12'h020, 32'h0, 0, "R3 word readback");
        access(1, 2'b10, 12'h035, 32'hCAFEF00D, 0, "R6 word write");
        access(0, 2'b10, 12'h034, 32'h0, 0, "R7 word read");
        access(0, 2'b01, 12'h036, 32'h0, 0, "R7 upper read after word read");
        access(0, 2'b01, 12'h020, 32'h0, 0, "R4 lower read");
        access(0, 2'b01, 12'h022, 32'h0, 0, "R5 upper read");
        access(0, 2'b01, 12'h02A, 32'h0, 0, "R5 upper read repeated");
        access(1, 2'b01, 12'h040, 32'h00005A5A, 0, "R2 lower write before bad width");
        access(1, 2'b00, 12'h040, 32'h000000FF, 0, "R8 byte write");
        access(0, 2'b00, 12'h041, 32'h0, 0, "R8 byte read");
        access(1, 2'b11, 12'h042, 32'h00001111, 0, "R8 reserved size write");
        access(0, 2'b01, 12'h046, 32'h0, 0, "R8 read latch unchanged");
        access(1, 2'b01, 12'h042, 32'h00007777, 0, "R8 write latch unchanged");
        access(0, 2'b10, 12'h040, 32'h0, 0, "R8 word readback");
        access(0, 2'b01, 12'h034, 32'h0, 1, "R9 lower read with junk");
        access(1, 2'b01, 12'h050, 32'h00003C3C, 1, "R9 lower write with junk");
        access(1, 2'b10, 12'h060, 32'h13579BDF, 1, "R9 word write with junk");
        access(1, 2'b01, 12'h052, 32'h0000C3C3, 0, "R9 upper write after junk");
        access(0, 2'b10, 12'h050, 32'h0, 0, "R9 word readback");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule